// File: doc/BRIEF.md
# Quadrature Clock Phase Generator

This block derives a pair of quadrature square waves, an in-phase output and a quadrature output lagging it by 90 degrees, from a single input clock. It also produces a four-bit phase bus in which exactly one bit is high at a time. Each bit marks one quarter of the output period, so the bus can drive four non-overlapping switching phases. Two state flops form a Johnson-style loop. The lead flop loads the inverse of the lag flop, and the lag flop loads the lead flop. The in-phase output is the lead flop and the quadrature output is the lag flop.

The block has two division modes. In divide-by-4 mode both flops advance on the falling edge of the input clock, so the outputs run at one quarter of the input frequency. In divide-by-2 mode the lead flop advances on the rising edge and the lag flop on the falling edge. One output period then spans four input edges, which is two input cycles. This mode gives true quadrature only when the input clock has a 50% duty cycle. The lead flop's clock is formed as the input clock XOR a mode bit, so the normal clock and the inverted clock pass through equal logic.

The mode select is captured only while reset is held. Each reset therefore fixes the division ratio until the next reset.

Top module: `qpg_quad_gen`

## Requirements
- R1: While `arst` is high, both state flops are cleared asynchronously: `i_out`=0, `q_out`=0 and `phase`=4'b0001.
- R2: Out of reset the state {i_out,q_out} steps 00, 10, 11, 01 and then back to 00, and repeats indefinitely.
- R3: In divide-by-4 mode (`div2_sel` captured as 0), the state advances only on falling edges of `clk_in`. Each output therefore has a period of 4 input cycles, and `q_out` follows `i_out` one input cycle later.
- R4: In divide-by-2 mode (`div2_sel` captured as 1), `i_out` changes only on rising edges and `q_out` only on falling edges. The output period is 2 input cycles, and `q_out` follows `i_out` half an input cycle later.
- R5: `phase` is one-hot with a fixed mapping from state {i_out,q_out}: 00 gives bit 0, 10 gives bit 1, 11 gives bit 2 and 01 gives bit 3. Exactly one bit is high at every instant after reset.
- R6: `div2_sel` is sampled on rising edges of `clk_in` only while `arst` is high. A change of `div2_sel` outside reset leaves the division mode unchanged until the next reset.
- R7: Each phase bit stays high for exactly one quarter of the output period. That is one full input cycle in divide-by-4 mode and one half input cycle in divide-by-2 mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| arst | input | 1 | Asynchronous reset, active high |
| div2_sel | input | 1 | Mode select, 1 = divide-by-2 dual-edge, 0 = divide-by-4; captured only during reset |
| i_out | output | 1 | In-phase output (lead flop) |
| q_out | output | 1 | Quadrature output (lag flop), 90 degrees behind `i_out` |
| phase | output | 4 | One-hot quarter-period phase bus |

## Verification
A corrupted state flop shows up at the ports at the very next active clock edge. It appears either as a skipped or reversed step in the {i_out,q_out} sequence or as an illegal phase code, and the two-flop loop never corrects it. A wrong edge assignment in divide-by-2 mode appears within one input cycle: `i_out` and `q_out` then differ before a rising edge or match before a falling edge. The bench samples one nanosecond after every edge of the input clock, so any such error is caught on the edge where it first appears. The bench also changes the mode select while out of reset and counts output rising edges, which confirms the captured ratio.

// File: rtl/qpg_pkg.sv
package qpg_pkg;

  localparam int STATE_W    = 2;
  localparam int NUM_PHASES = 1 << STATE_W;
  localparam int PH_IDX_W   = $clog2(NUM_PHASES);

  // next value for the lead flop (inverse of lag)
  function automatic logic lead_next(input logic lag_now);
    return ~lag_now;
  endfunction

  // next value for the lag flop (copy of lead)
  function automatic logic lag_next(input logic lead_now);
    return lead_now;
  endfunction

  // {lead,lag} code that owns phase index k: a two-bit Gray walk
  function automatic logic [STATE_W-1:0] code_of_phase(input logic [PH_IDX_W-1:0] k);
    return {k[1] ^ k[0], k[1]};
  endfunction

endpackage

// File: rtl/qpg_mode_hold.sv
module qpg_mode_hold (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  output logic div2_mode
);
  // the select is loaded only while reset is held
  always_ff @(posedge clk) begin
    if (rst) div2_mode <= sel;
  end
endmodule

// File: rtl/qpg_state_flops.sv
module qpg_state_flops
  import qpg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic div2_mode,
  output logic lead,
  output logic lag
);
  logic lead_clk;

  // same XOR path for both modes: inverted clock moves the lead flop to the rising edge
  assign lead_clk = clk ^ div2_mode;

  always_ff @(negedge lead_clk or posedge rst) begin
    if (rst) lead <= 1'b0;
    else     lead <= lead_next(lag);
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) lag <= 1'b0;
    else     lag <= lag_next(lead);
  end
endmodule

// File: rtl/qpg_phase_decode.sv
module qpg_phase_decode
  import qpg_pkg::*;
(
  input  logic [STATE_W-1:0]    state,
  output logic [NUM_PHASES-1:0] phase
);
  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_ph
    assign phase[k] = (state == code_of_phase(PH_IDX_W'(k)));
  end
endmodule

// File: rtl/qpg_quad_gen.sv
module qpg_quad_gen
  import qpg_pkg::*;
(
  input  logic                  clk_in,
  input  logic                  arst,
  input  logic                  div2_sel,
  output logic                  i_out,
  output logic                  q_out,
  output logic [NUM_PHASES-1:0] phase
);
  logic div2_mode;
  logic st_lead;
  logic st_lag;

  qpg_mode_hold u_mode (
    .clk       (clk_in),
    .rst       (arst),
    .sel       (div2_sel),
    .div2_mode (div2_mode)
  );

  qpg_state_flops u_flops (
    .clk       (clk_in),
    .rst       (arst),
    .div2_mode (div2_mode),
    .lead      (st_lead),
    .lag       (st_lag)
  );

  qpg_phase_decode u_dec (
    .state (({st_lead, st_lag})),
    .phase (phase)
  );

  assign i_out = st_lead;
  assign q_out = st_lag;
endmodule

// File: rtl/qpg_quad_gen_chk.sv
module qpg_quad_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       div2_mode,
  input logic       i_out,
  input logic       q_out,
  input logic [3:0] phase
);
  logic armed_p, armed_n;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) armed_p <= 1'b0;
    else     armed_p <= 1'b1;
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) armed_n <= 1'b0;
    else     armed_n <= 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |-> (phase == 4'b0001 && !i_out && !q_out));

  // R2/R3: divide-by-4 - each falling edge shifts I into Q and inverts Q into I
  p_div4_step_r3: assert property (@(negedge clk) disable iff (rst || div2_mode)
    armed_n |-> (i_out == !$past(q_out) && q_out == $past(i_out)));

  // R4: before a rising edge I and Q agree; before a falling edge they differ
  p_div2_rise_r4: assert property (@(posedge clk) disable iff (rst || !div2_mode)
    armed_p |-> (i_out == q_out));
  p_div2_fall_r4: assert property (@(negedge clk) disable iff (rst || !div2_mode)
    armed_n |-> (i_out != q_out));

  p_onehot_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);
  p_onehot_fall_r5: assert property (@(negedge clk) disable iff (rst)
    $countones(phase) == 1);

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
    armed_p |-> $stable(div2_mode));
endmodule

bind qpg_quad_gen qpg_quad_gen_chk u_chk (
  .clk       (clk_in),
  .rst       (arst),
  .div2_mode (div2_mode),
  .i_out     (i_out),
  .q_out     (q_out),
  .phase     (phase)
);

// File: tb/qpg_quad_gen_test.sv
module qpg_quad_gen_test;
  logic       clk_in = 1'b0;
  logic       arst;
  logic       div2_sel;
  logic       i_out, q_out;
  logic [3:0] phase;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // expected {i,q,phase} for successive steps after reset: 10, 11, 01, 00
  localparam logic [5:0] VEC [4] = '{
    {2'b10, 4'b0010},
    {2'b11, 4'b0100},
    {2'b01, 4'b1000},
    {2'b00, 4'b0001}
  };
  localparam logic [5:0] RST_VEC = {2'b00, 4'b0001};

  qpg_quad_gen uut (
    .clk_in   (clk_in),
    .arst     (arst),
    .div2_sel (div2_sel),
    .i_out    (i_out),
    .q_out    (q_out),
    .phase    (phase)
  );

  always #2 clk_in = ~clk_in;  // 250 MHz

  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {i_out, q_out, phase};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // hold reset over two rising edges, release just after a falling edge
  task automatic do_reset(input logic m);
    arst = 1'b1;
    div2_sel = m;
    repeat (2) @(posedge clk_in);
    @(negedge clk_in); #1;
    chk("R1 reset state", RST_VEC);
    arst = 1'b0;
  endtask

  // divide-by-4 walk: unchanged after rising edges, one step after falling edges
  task automatic walk_div4(input int cycles, input string req, output int rises);
    logic [5:0] prev;
    logic       last_i;
    prev = RST_VEC;
    last_i = 1'b0;
    rises = 0;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk_in); #1;
      chk({req, " R3/R7 hold across rising edge"}, prev);
      @(negedge clk_in); #1;
      chk({req, " R2/R3/R5 step"}, VEC[k % 4]);
      if (i_out && !last_i) rises++;
      last_i = i_out;
      prev = VEC[k % 4];
    end
  endtask

  // divide-by-2 walk: one step on every edge, starting with a rising edge
  task automatic walk_div2(input int edges, input string req, output int rises);
    logic last_i;
    last_i = 1'b0;
    rises = 0;
    for (int k = 0; k < edges; k++) begin
      if (k % 2 == 0) @(posedge clk_in); else @(negedge clk_in);
      #1;
      chk({req, " R2/R4/R5/R7 step"}, VEC[k % 4]);
      if (i_out && !last_i) rises++;
      last_i = i_out;
    end
  endtask

  initial begin
    int r;
    arst = 1'b0;
    div2_sel = 1'b0;
    #1 arst = 1'b1;

    // divide-by-4 baseline, 16 input cycles -> 4 output periods
    do_reset(1'b0);
    walk_div4(16, "div4", r);
    chk_int("R3 div4 i_out rises in 16 cycles", r, 4);

    // R6: select flips outside reset, ratio must stay divide-by-4
    div2_sel = 1'b1;
    walk_div4(8, "R6 div4 after select change", r);
    chk_int("R6 div4 rises after select change", r, 2);

    // R1: asynchronous reset mid-period, before any clock edge
    @(posedge clk_in); #0.5;
    arst = 1'b1; #0.5;
    chk("R1 async clear mid-run", RST_VEC);

    // divide-by-2, 16 input cycles -> 8 output periods
    do_reset(1'b1);
    walk_div2(32, "div2", r);
    chk_int("R4 div2 i_out rises in 16 cycles", r, 8);

    // R6: select dropped outside reset, ratio must stay divide-by-2
    div2_sel = 1'b0;
    walk_div2(16, "R6 div2 after select change", r);
    chk_int("R6 div2 rises after select change", r, 4);

    // back to divide-by-4 through reset to confirm recapture
    do_reset(1'b0);
    walk_div4(4, "R6 recapture div4", r);
    chk_int("R6 recapture div4 rises", r, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule